// File: doc/BRIEF.md
# Control Unit Command and Status Register

This block is the host-facing command and status register of a channel-attached control unit. Host software uses it to pick a function and start it with a GO bit. Through the same register it enables interrupts, arms the busy and burst behaviours, holds the stacked-status flag and two extended address bits, and asks the unit to go on-line. A channel sequencer, which is outside this block, supplies a lockout level, the current phase number, two time-slot strobes for phase 4, sequence start and response events, and a signal that marks the instants at which an on-line change is allowed.

The block returns a one-cycle start strobe for data and status functions and a one-cycle unit reset strobe for function 0. It also drives the interrupt request, the request-in level, the operating on-line state and a flag that says when the sequencer may release lockout. Reads are combinational from the register state.

Top module: `cu_ctl_reg`

## Requirements
- R1: After reset, rd_data reads 0 and every output is 0 except lock_release_ok, which is 1 while phase is 0 or 7.
- R2: Register layout: bit0 GO, bits 2:1 function code (0 reset unit, 1 input transfer, 2 output transfer, 3 present status), bit3 interrupt enable, bit4 DONE, bit5 unit busy, bit6 busy enable, bit7 end-on-busy enable, bit8 burst enable, bit9 stop on parity, bit10 stacked status, bits 12:11 extended address, bit13 on-line request, bit14 operating on-line (read-only), bit15 reads 0. With lockout at 0, a write updates bits 7:0 when wr_be[0] is set and bits 15:8 when wr_be[1] is set. The update takes effect at the write edge.
- R3: With lockout at 1, a write changes no field except interrupt enable (bit3) and DONE (bit4).
- R4: A host write to DONE takes effect only while phase is 0 or 7.
- R5: In phase 4, slot_a clears DONE and slot_b sets DONE at the next edge. Both override any host write in the same cycle.
- R6: irq is 1 exactly when DONE and interrupt enable are both 1.
- R7: GO reads back as 0. An unlocked write with bit0=1 and a nonzero function code in the same write raises start_pulse for exactly the following cycle.
- R8: An unlocked GO write with function code 0 raises unit_reset_pulse for the following cycle. It also clears DONE, unit busy and stacked status, and drops req_in.
- R9: req_in is set by cui_start while the stored function code is nonzero. It is cleared by seq_resp or by a unit reset, and clearing wins over setting.
- R10: seq_resp while busy enable is 1 sets unit busy at the next edge, overriding a host write of that bit.
- R11: online_op takes the value of the on-line request bit at an edge where switch_ok is 1, and otherwise holds.
- R12: lock_release_ok is 1 exactly when DONE is 0 and phase is 0 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 2 | Byte enables, bit0 for the low byte |
| wr_data | input | 16 | Host write data |
| lockout | input | 1 | Unit is busy with the channel; gates host writes |
| phase | input | 3 | Current sequencer phase |
| slot_a | input | 1 | First time slot of phase 4 |
| slot_b | input | 1 | Second time slot of phase 4 |
| cui_start | input | 1 | Start of a unit-initiated sequence |
| seq_resp | input | 1 | Unit responds to a sequence of either kind |
| switch_ok | input | 1 | On-line state may change now |
| rd_data | output | 16 | Register read value |
| start_pulse | output | 1 | One-cycle start of a nonzero function |
| unit_reset_pulse | output | 1 | One-cycle unit reset (function 0) |
| irq | output | 1 | Interrupt request |
| req_in | output | 1 | Request-in level toward the channel |
| online_op | output | 1 | Operating on-line stage |
| lock_release_ok | output | 1 | Lockout may be released |

## Verification
The assertions assume that slot_a and slot_b are never high together and that neither strobe means anything outside phase 4. They also assume that DONE changes only through a host write, a GO of function 0, or the phase-4 slots. The random stimulus draws slot_a and slot_b from one selector, so at most one of them is high at a time. It biases phase toward 0, 4 and 7 so that DONE loads, slot actions and ignored DONE writes all occur often. Lockout, byte enables, sequence events and switch_ok are drawn independently each cycle.

// File: rtl/cu_ctl_reg.sv
module cu_ctl_reg #(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic          lockout,
  input  logic [PW-1:0] phase,
  input  logic          slot_a,
  input  logic          slot_b,
  input  logic          cui_start,
  input  logic          seq_resp,
  input  logic          switch_ok,
  output logic [DW-1:0] rd_data,
  output logic          start_pulse,
  output logic          unit_reset_pulse,
  output logic          irq,
  output logic          req_in,
  output logic          online_op,
  output logic          lock_release_ok
);
  localparam logic [PW-1:0] PH_IDLE = '0;
  localparam logic [PW-1:0] PH_END  = '1;
  localparam logic [PW-1:0] PH_INT  = PW'(4);

  logic [1:0] fn_q, xba_q;
  logic ien_q, done_q, busy_q, ben_q, cue_q, burst_q, par_q, stk_q, onreq_q;

  wire ph_load = (phase == PH_IDLE) || (phase == PH_END);
  wire ph_int  = (phase == PH_INT);
  wire wr_lo   = wr_en && wr_be[0];
  wire wr_hi   = wr_en && wr_be[1];
  wire go_hit  = wr_lo && !lockout && wr_data[0];
  wire go_rst  = go_hit && (wr_data[2:1] == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q <= '0; xba_q <= '0; ien_q <= 1'b0; done_q <= 1'b0; busy_q <= 1'b0;
      ben_q <= 1'b0; cue_q <= 1'b0; burst_q <= 1'b0; par_q <= 1'b0;
      stk_q <= 1'b0; onreq_q <= 1'b0; online_op <= 1'b0; req_in <= 1'b0;
      start_pulse <= 1'b0; unit_reset_pulse <= 1'b0;
    end else begin
      if (wr_lo) begin
        ien_q <= wr_data[3];
        if (ph_load) done_q <= wr_data[4];
        if (!lockout) begin
          fn_q   <= wr_data[2:1];
          busy_q <= wr_data[5];
          ben_q  <= wr_data[6];
          cue_q  <= wr_data[7];
        end
      end
      if (wr_hi && !lockout) begin
        burst_q <= wr_data[8];
        par_q   <= wr_data[9];
        stk_q   <= wr_data[10];
        xba_q   <= wr_data[12:11];
        onreq_q <= wr_data[13];
      end
      if (go_rst) begin
        done_q <= 1'b0;
        busy_q <= 1'b0;
        stk_q  <= 1'b0;
      end
      if (ben_q && seq_resp) busy_q <= 1'b1;
      if (ph_int && slot_a) done_q <= 1'b0;
      if (ph_int && slot_b) done_q <= 1'b1;

      if (cui_start && fn_q != 2'd0) req_in <= 1'b1;
      if (seq_resp || go_rst) req_in <= 1'b0;

      if (switch_ok) online_op <= onreq_q;
      start_pulse      <= go_hit && !go_rst;
      unit_reset_pulse <= go_rst;
    end
  end

  assign rd_data = {1'b0, online_op, onreq_q, xba_q, stk_q, par_q, burst_q,
                    cue_q, ben_q, busy_q, done_q, ien_q, fn_q, 1'b0};
  assign irq = done_q && ien_q;
  assign lock_release_ok = !done_q && ph_load;

  p_locked_fn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> $stable(fn_q));
  p_locked_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !seq_resp) |=> $stable(rd_data[13:5]));
  p_done_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph_load && !ph_int && !go_hit) |=> $stable(done_q));
  p_slot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_int && slot_b && !slot_a) |=> irq == ien_q);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, unit_reset_pulse}));
  p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unit_reset_pulse |-> !req_in);
  p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_resp && ben_q) |=> busy_q);
  p_online_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_ok |=> $stable(online_op));
endmodule

// File: tb/test_cu_ctl_reg.sv
`timescale 1ns/1ps
module test_cu_ctl_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, lockout = 0, slot_a = 0, slot_b = 0, cui_start = 0, seq_resp = 0, switch_ok = 0;
  logic [1:0] wr_be = 0;
  logic [15:0] wr_data = 0;
  logic [2:0] phase = 0;
  logic [15:0] rd_data;
  logic start_pulse, unit_reset_pulse, irq, req_in, online_op, lock_release_ok;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cu_ctl_reg i_cu_ctl_reg (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .lockout(lockout), .phase(phase), .slot_a(slot_a), .slot_b(slot_b),
    .cui_start(cui_start), .seq_resp(seq_resp), .switch_ok(switch_ok), .rd_data(rd_data),
    .start_pulse(start_pulse), .unit_reset_pulse(unit_reset_pulse), .irq(irq),
    .req_in(req_in), .online_op(online_op), .lock_release_ok(lock_release_ok));

  logic [1:0] m_fn, m_xba;
  logic m_ien, m_done, m_busy, m_ben, m_cue, m_burst, m_par, m_stk, m_onreq, m_onop, m_go, m_rst, m_req;

  function automatic logic [15:0] exp_rd();
    return {1'b0, m_onop, m_onreq, m_xba, m_stk, m_par, m_burst, m_cue, m_ben,
            m_busy, m_done, m_ien, m_fn, 1'b0};
  endfunction

  task automatic model_clear();
    {m_fn, m_xba, m_ien, m_done, m_busy, m_ben, m_cue, m_burst, m_par, m_stk,
     m_onreq, m_onop, m_go, m_rst, m_req} = '0;
  endtask

  // next state from the requirements, using inputs now on the pins
  task automatic model_step();
    logic [1:0] fn_old = m_fn;
    logic ben_old = m_ben, onreq_old = m_onreq;
    logic ld = (phase == 3'd0) || (phase == 3'd7);
    logic go = wr_en && wr_be[0] && !lockout && wr_data[0];
    logic gr = go && (wr_data[2:1] == 2'd0);
    if (wr_en && wr_be[0]) begin
      m_ien = wr_data[3];
      if (ld) m_done = wr_data[4];
      if (!lockout) begin
        m_fn = wr_data[2:1]; m_busy = wr_data[5]; m_ben = wr_data[6]; m_cue = wr_data[7];
      end
    end
    if (wr_en && wr_be[1] && !lockout) begin
      m_burst = wr_data[8]; m_par = wr_data[9]; m_stk = wr_data[10];
      m_xba = wr_data[12:11]; m_onreq = wr_data[13];
    end
    if (gr) begin m_done = 0; m_busy = 0; m_stk = 0; end
    if (ben_old && seq_resp) m_busy = 1;
    if (phase == 3'd4 && slot_a) m_done = 0;
    if (phase == 3'd4 && slot_b) m_done = 1;
    if (cui_start && fn_old != 0) m_req = 1;
    if (seq_resp || gr) m_req = 0;
    if (switch_ok) m_onop = onreq_old;
    m_go = go && !gr;
    m_rst = gr;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, rd_data, exp_rd());
    chk("R6 irq", 16'(irq), 16'(m_done & m_ien));
    chk("R7 start_pulse", 16'(start_pulse), 16'(m_go));
    chk("R8 unit_reset_pulse", 16'(unit_reset_pulse), 16'(m_rst));
    chk("R9 req_in", 16'(req_in), 16'(m_req));
    chk("R11 online_op", 16'(online_op), 16'(m_onop));
    chk("R12 lock_release_ok", 16'(lock_release_ok),
        16'(!m_done && (phase == 3'd0 || phase == 3'd7)));
  endtask

  task automatic cyc(input string tag, input logic we, input logic [1:0] be, input logic [15:0] d,
                     input logic lk, input logic [2:0] ph, input logic sa, input logic sb,
                     input logic cs, input logic sr, input logic so);
    wr_en = we; wr_be = be; wr_data = d; lockout = lk; phase = ph;
    slot_a = sa; slot_b = sb; cui_start = cs; seq_resp = sr; switch_ok = so;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input string tag, input logic [2:0] ph);
    cyc(tag, 0, 2'b00, 16'h0, 0, ph, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    chk("R1 reset rd", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 full unlocked write, both lanes; GO bit reads back 0
    cyc("R2 write", 1, 2'b11, 16'hBFFE, 0, 3'd0, 0, 0, 0, 0, 0);
    cyc("R2 low lane only", 1, 2'b01, 16'h0000, 0, 3'd0, 0, 0, 0, 0, 0);
    // R3 locked write: only ien and done move
    cyc("R3 locked", 1, 2'b11, 16'h3FF8, 1, 3'd7, 0, 0, 0, 0, 0);
    cyc("R3 locked clear", 1, 2'b11, 16'h0000, 1, 3'd7, 0, 0, 0, 0, 0);
    // R4 DONE write outside phase 0/7 ignored
    cyc("R4 ignored", 1, 2'b01, 16'h0018, 0, 3'd3, 0, 0, 0, 0, 0);
    // R5 slot b sets, slot a clears, both beat a host write
    cyc("R5 slot_b", 0, 2'b00, 16'h0, 0, 3'd4, 0, 1, 0, 0, 0);
    cyc("R5 slot_a", 1, 2'b01, 16'h0010, 0, 3'd4, 1, 0, 0, 0, 0);
    // R7 GO with function 2
    cyc("R7 go", 1, 2'b01, 16'h0045, 0, 3'd0, 0, 0, 0, 0, 0);
    idle("R7 one cycle", 3'd0);
    // R9 request-in, R10 busy set by response
    cyc("R9 set", 0, 2'b00, 16'h0, 0, 3'd1, 0, 0, 1, 0, 0);
    cyc("R10 busy", 0, 2'b00, 16'h0, 0, 3'd1, 0, 0, 0, 1, 0);
    cyc("R9 set again", 1, 2'b10, 16'h2400, 0, 3'd7, 0, 1, 1, 0, 0);
    // R8 GO with function 0
    cyc("R8 go reset", 1, 2'b01, 16'h0009, 0, 3'd7, 0, 0, 0, 0, 0);
    // R11 switch
    cyc("R11 switch", 0, 2'b00, 16'h0, 0, 3'd0, 0, 0, 0, 0, 1);
    cyc("R11 hold", 1, 2'b10, 16'h0000, 0, 3'd0, 0, 0, 0, 0, 0);
    cyc("R11 switch off", 0, 2'b00, 16'h0, 0, 3'd0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4000; i++) begin
      int ps = $urandom % 8;
      int sl = $urandom % 3;
      logic [2:0] ph = (ps < 2) ? 3'd0 : (ps < 4) ? 3'd4 : (ps < 6) ? 3'd7 : 3'($urandom);
      cyc("R2 random", 1'($urandom % 3 != 0), 2'($urandom), 16'($urandom),
          1'($urandom % 3 == 0), ph, sl == 1, sl == 2, 1'($urandom % 4 == 0),
          1'($urandom % 5 == 0), 1'($urandom % 4 == 0));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule